// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a memory-mapped general-purpose I/O controller for 128 pins. The pins are grouped into four banks of 32. Software reaches it over a simple 32-bit register bus with an address, a write strobe, write data and combinational read data. Each bank has these registers: a direction register, an output latch, a pin-level view, rising-edge and falling-edge enables, a sticky edge-status register and two alternate-function storage words. Software never writes the output latch directly. It sets bits through a write-one-to-set port and clears them through a write-one-to-clear port. Pin `p` is in bank `p/32` at bit `p mod 32`.

Every pin input passes through a two-flop synchroniser. The block then compares the synchronised sample with the one from the previous cycle to find edges on input pins. A detected edge sets a sticky status bit when that edge direction is enabled for the pin. The status bits drive three interrupt lines. Pin 0 and pin 1 each have a dedicated line, and the third line is the OR of all other status bits. When a synchronised level change appears on an input pin that belongs to a fixed wake set, the block raises a wake request for one cycle.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset every register reads zero: direction, latch, enables, status, set-readback and alternate-function words. `pinDir`, `pinOut`, all three interrupt lines, `wakeReq` and `busErr` are low.
- R2: Direction bit 1 makes the pin an output. `pinDir` mirrors the direction registers and `pinOut` mirrors the output latch. A level read (bank 0..3 at 0x000, 0x004, 0x008, 0x100) returns the latch bit for output pins and the synchronised input for input pins. Direction sits at 0x00C, 0x010, 0x014 and 0x10C.
- R3: A write to the set port (0x018, 0x01C, 0x020, 0x118) ORs the data into the latch. A write to the clear port (0x024, 0x028, 0x02C, 0x124) clears the latch bits that are 1 in the data. Zero bits leave the latch unchanged.
- R4: A read of a set port returns the value last written to it. A read of a clear port returns 0x00007A69.
- R5: An input pin with a 0-to-1 change sets its status bit only if its rising enable (0x030, 0x034, 0x038, 0x130) is 1. A 1-to-0 change sets it only if its falling enable (0x03C, 0x040, 0x044, 0x13C) is 1. Status (0x048, 0x04C, 0x050, 0x148) becomes readable after the third rising clock edge that follows the pin change.
- R6: A pin whose direction bit is 1 never sets its status bit, whatever it does at `pinIn`.
- R7: Status bits stay set until software writes 1 to them. Zero bits in a status write have no effect.
- R8: `irqPin0` is status bit 0 of bank 0 and `irqPin1` is status bit 1 of bank 0. `irqOther` is the OR of every other status bit in all banks.
- R9: `wakeReq` is high for one cycle, the cycle after the second clock edge that follows a level change, when that input pin is in the wake mask. The mask is 0x8003FE1B for bank 0, 0x002001FC for bank 1, 0xEC080000 for bank 2 and 0x0012007F for bank 3. Pins outside the mask do not raise it.
- R10: At byte offsets 0x200 and above, reads return zero and writes change nothing and raise no error.
- R11: An offset below 0x200 that maps to no register, including any offset that is not word aligned, reads as zero. A write to such an offset raises `busErr` for exactly the one cycle after the write.
- R12: The alternate-function words are plain read/write storage. For bank b the low word is at 0x054+8b and the high word is at 0x058+8b.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busAddr | input | 12 | Byte offset of the access |
| busWr | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| busErr | output | 1 | One-cycle pulse after a write to an unmapped offset below 0x200 |
| pinIn | input | 128 | Asynchronous pin input levels |
| pinOut | output | 128 | Output latch values |
| pinDir | output | 128 | Pin direction, 1 = output |
| irqPin0 | output | 1 | Interrupt for pin 0 status |
| irqPin1 | output | 1 | Interrupt for pin 1 status |
| irqOther | output | 1 | Interrupt for all remaining status bits |
| wakeReq | output | 1 | Wake request on a level change of a wake-set input pin |

## Verification
The bench drives edges of both polarities with only the matching enable set, then with only the opposite enable set. A design that ignored the enables or swapped them would latch the wrong edges. It toggles a pin that is configured as output, so a design that does not gate by direction would set status on that pin. It writes zeros to status and confirms the bit stays set. It also clears a single bit with a write of 1, so a design that treats status as plain storage, or that clears on any write, would show up. Bank 3 is reached through its displaced offsets, and the tests cover the clear-port readback constant, a pin outside the wake mask, writes above the mapped window and unmapped or misaligned writes below it. A decoder that wraps addresses or misses the bank 3 gap would hit the wrong register, and would show a missing or false error pulse.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int BANKS = 4;
  localparam int BANK_W = 32;
  localparam int BANK_IDX_W = $clog2(BANKS);
  localparam int PINS = BANKS * BANK_W;
  localparam int GROUPS = 7;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_LEVEL, SEL_DIR, SEL_SET, SEL_CLR,
    SEL_RISE, SEL_FALL, SEL_STS, SEL_AFLO, SEL_AFHI
  } regSel_t;

  typedef struct packed {
    logic [BANKS-1:0] dirWr;
    logic [BANKS-1:0] setWr;
    logic [BANKS-1:0] clrWr;
    logic [BANKS-1:0] riseWr;
    logic [BANKS-1:0] fallWr;
    logic [BANKS-1:0] stsWr;
    logic [BANKS-1:0] afLoWr;
    logic [BANKS-1:0] afHiWr;
  } wrStrobe_t;

  // group order: level, dir, set, clr, rise, fall, status
  function automatic int groupOffset(int g, int b);
    if (b < 3) return g * 12 + b * 4;
    return 256 + g * 12;
  endfunction

  function automatic logic [BANK_W-1:0] wakeMask(int b);
    case (b)
      0: return 32'h8003FE1B;
      1: return 32'h002001FC;
      2: return 32'hEC080000;
      default: return 32'h0012007F;
    endcase
  endfunction
endpackage

// File: rtl/gpio_edge_decode.sv
module gpio_edge_decode
  import gpio_edge_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busWr,
  output regSel_t               rdSel,
  output logic [BANK_IDX_W-1:0] rdBank,
  output wrStrobe_t             strobe,
  output logic                  busErr
);
  localparam logic [ADDR_W-1:0] WINDOW = ADDR_W'(32'h200);

  logic inRange;
  logic badWr;

  always_comb begin
    rdSel = SEL_NONE;
    rdBank = '0;
    inRange = (busAddr < WINDOW) && (busAddr[1:0] == 2'b00);
    for (int b = 0; b < BANKS; b++) begin
      for (int g = 0; g < GROUPS; g++) begin
        if (inRange && busAddr == ADDR_W'(groupOffset(g, b))) begin
          rdSel = regSel_t'(4'(g + 1));
          rdBank = BANK_IDX_W'(b);
        end
      end
      if (inRange && busAddr == ADDR_W'(84 + 8 * b)) begin
        rdSel = SEL_AFLO;
        rdBank = BANK_IDX_W'(b);
      end
      if (inRange && busAddr == ADDR_W'(88 + 8 * b)) begin
        rdSel = SEL_AFHI;
        rdBank = BANK_IDX_W'(b);
      end
    end
  end

  always_comb begin
    strobe = '0;
    if (busWr) begin
      case (rdSel)
        SEL_DIR:  strobe.dirWr[rdBank] = 1'b1;
        SEL_SET:  strobe.setWr[rdBank] = 1'b1;
        SEL_CLR:  strobe.clrWr[rdBank] = 1'b1;
        SEL_RISE: strobe.riseWr[rdBank] = 1'b1;
        SEL_FALL: strobe.fallWr[rdBank] = 1'b1;
        SEL_STS:  strobe.stsWr[rdBank] = 1'b1;
        SEL_AFLO: strobe.afLoWr[rdBank] = 1'b1;
        SEL_AFHI: strobe.afHiWr[rdBank] = 1'b1;
        default: ;
      endcase
    end
  end

  assign badWr = busWr && (busAddr < WINDOW) && (rdSel == SEL_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) busErr <= 1'b0;
    else busErr <= badWr;
  end
endmodule

// File: rtl/gpio_edge_regs.sv
module gpio_edge_regs
  import gpio_edge_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  wrStrobe_t             strobe,
  input  logic [BANK_W-1:0]     busWdata,
  input  regSel_t               rdSel,
  input  logic [BANK_IDX_W-1:0] rdBank,
  output logic [BANK_W-1:0]     busRdata,
  input  logic [PINS-1:0]       pinIn,
  output logic [PINS-1:0]       pinOut,
  output logic [PINS-1:0]       pinDir,
  output logic                  irqPin0,
  output logic                  irqPin1,
  output logic                  irqOther,
  output logic                  wakeReq
);
  logic [BANK_W-1:0] dirR   [BANKS];
  logic [BANK_W-1:0] latchR [BANKS];
  logic [BANK_W-1:0] riseEn [BANKS];
  logic [BANK_W-1:0] fallEn [BANKS];
  logic [BANK_W-1:0] stsR   [BANKS];
  logic [BANK_W-1:0] setLast[BANKS];
  logic [BANK_W-1:0] afLo   [BANKS];
  logic [BANK_W-1:0] afHi   [BANKS];
  logic [BANK_W-1:0] sync1  [BANKS];
  logic [BANK_W-1:0] sync2  [BANKS];
  logic [BANK_W-1:0] prevS  [BANKS];
  logic [BANKS-1:0]  wakeBank;
  logic [BANKS-1:0]  otherBank;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [BANK_W-1:0] edgeHit;
    logic [BANK_W-1:0] stsClr;

    assign edgeHit = ~dirR[b] & ((sync2[b] & ~prevS[b] & riseEn[b]) |
                                 (~sync2[b] & prevS[b] & fallEn[b]));
    assign stsClr = strobe.stsWr[b] ? busWdata : '0;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dirR[b] <= '0;   latchR[b] <= '0;  riseEn[b] <= '0;
        fallEn[b] <= '0; stsR[b] <= '0;    setLast[b] <= '0;
        afLo[b] <= '0;   afHi[b] <= '0;    sync1[b] <= '0;
        sync2[b] <= '0;  prevS[b] <= '0;
      end else begin
        sync1[b] <= pinIn[b*BANK_W +: BANK_W];
        sync2[b] <= sync1[b];
        prevS[b] <= sync2[b];
        stsR[b] <= (stsR[b] & ~stsClr) | edgeHit;
        if (strobe.dirWr[b]) dirR[b] <= busWdata;
        if (strobe.setWr[b]) begin
          latchR[b] <= latchR[b] | busWdata;
          setLast[b] <= busWdata;
        end else if (strobe.clrWr[b]) begin
          latchR[b] <= latchR[b] & ~busWdata;
        end
        if (strobe.riseWr[b]) riseEn[b] <= busWdata;
        if (strobe.fallWr[b]) fallEn[b] <= busWdata;
        if (strobe.afLoWr[b]) afLo[b] <= busWdata;
        if (strobe.afHiWr[b]) afHi[b] <= busWdata;
      end
    end

    assign pinOut[b*BANK_W +: BANK_W] = latchR[b];
    assign pinDir[b*BANK_W +: BANK_W] = dirR[b];
    assign wakeBank[b] = |((sync2[b] ^ prevS[b]) & ~dirR[b] & wakeMask(b));
    if (b == 0) begin : g_low
      assign otherBank[b] = |stsR[b][BANK_W-1:2];
    end else begin : g_high
      assign otherBank[b] = |stsR[b];
    end
  end

  assign irqPin0 = stsR[0][0];
  assign irqPin1 = stsR[0][1];
  assign irqOther = |otherBank;
  assign wakeReq = |wakeBank;

  always_comb begin
    case (rdSel)
      SEL_LEVEL: busRdata = (latchR[rdBank] & dirR[rdBank]) |
                            (sync2[rdBank] & ~dirR[rdBank]);
      SEL_DIR:   busRdata = dirR[rdBank];
      SEL_SET:   busRdata = setLast[rdBank];
      SEL_CLR:   busRdata = 32'h00007A69;
      SEL_RISE:  busRdata = riseEn[rdBank];
      SEL_FALL:  busRdata = fallEn[rdBank];
      SEL_STS:   busRdata = stsR[rdBank];
      SEL_AFLO:  busRdata = afLo[rdBank];
      SEL_AFHI:  busRdata = afHi[rdBank];
      default:   busRdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              busErr,
  input  logic [PINS-1:0]   pinIn,
  output logic [PINS-1:0]   pinOut,
  output logic [PINS-1:0]   pinDir,
  output logic              irqPin0,
  output logic              irqPin1,
  output logic              irqOther,
  output logic              wakeReq
);
  regSel_t               rdSel;
  logic [BANK_IDX_W-1:0] rdBank;
  wrStrobe_t             strobe;

  gpio_edge_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWr(busWr),
    .rdSel(rdSel), .rdBank(rdBank), .strobe(strobe), .busErr(busErr)
  );

  gpio_edge_regs u_regs (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .busWdata(busWdata),
    .rdSel(rdSel), .rdBank(rdBank), .busRdata(busRdata), .pinIn(pinIn),
    .pinOut(pinOut), .pinDir(pinDir), .irqPin0(irqPin0), .irqPin1(irqPin1),
    .irqOther(irqOther), .wakeReq(wakeReq)
  );
endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk
  import gpio_edge_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic              busErr,
  input logic [PINS-1:0]   pinOut,
  input logic [PINS-1:0]   pinDir,
  input logic              irqPin0,
  input logic              irqOther
);
  localparam logic [ADDR_W-1:0] WINDOW = ADDR_W'(32'h200);

  a_r11_err_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busErr) |-> $past(busWr));

  a_r10_no_err_above_window: assert property (@(posedge clk) disable iff (!rst_n)
    (busWr && busAddr >= WINDOW) |=> !busErr);

  a_r2_dir_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !busWr |=> $stable(pinDir));

  a_r3_latch_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !busWr |=> $stable(pinOut));

  a_r7_irq0_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irqPin0) |-> $past(busWr));

  a_r7_other_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irqOther) |-> $past(busWr));
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWr(busWr),
  .busErr(busErr), .pinOut(pinOut), .pinDir(pinDir),
  .irqPin0(irqPin0), .irqOther(irqOther)
);

// File: tb/gpio_edge_ctrl_tb.sv
module gpio_edge_ctrl_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic [11:0] busAddr = '0;
  logic busWr = 0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic busErr;
  logic [127:0] pinIn = '0;
  logic [127:0] pinOut, pinDir;
  logic irqPin0, irqPin1, irqOther, wakeReq;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  gpio_edge_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .busErr(busErr),
    .pinIn(pinIn), .pinOut(pinOut), .pinDir(pinDir), .irqPin0(irqPin0),
    .irqPin1(irqPin1), .irqOther(irqOther), .wakeReq(wakeReq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1;
    @(negedge clk);
    busWr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic setPin(input int p, input logic v, output logic wake);
    @(negedge clk);
    pinIn[p] = v;
    repeat (2) @(negedge clk);
    wake = wakeReq;
    @(negedge clk);
  endtask

  task automatic testReset();
    logic [31:0] d;
    rd(12'h00C, d); chk("R1 dir0", d, 0);
    rd(12'h130, d); chk("R1 rise3", d, 0);
    rd(12'h048, d); chk("R1 sts0", d, 0);
    rd(12'h06C, d); chk("R1 afLo3", d, 0);
    chk("R1 pinDir", 32'(|pinDir), 0);
    chk("R1 outs", {27'b0, irqPin0, irqPin1, irqOther, wakeReq, busErr}, 0);
  endtask

  task automatic testOutputs();
    logic [31:0] d;
    wr(12'h10C, 32'h0000_00F0);
    chk("R2 pinDir bank3", pinDir[127:96], 32'h0000_00F0);
    wr(12'h118, 32'h0000_0F30);
    chk("R3 set latch", pinOut[127:96], 32'h0000_0F30);
    wr(12'h124, 32'h0000_0110);
    chk("R3 clear latch", pinOut[127:96], 32'h0000_0E20);
    pinIn[127:96] = 32'h0000_000F;
    repeat (3) @(negedge clk);
    rd(12'h100, d); chk("R2 level mix", d, 32'h0000_002F);
    rd(12'h118, d); chk("R4 set readback", d, 32'h0000_0F30);
    rd(12'h124, d); chk("R4 clear read", d, 32'h0000_7A69);
    pinIn[127:96] = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic testEdges();
    logic [31:0] d;
    logic w;
    wr(12'h030, 32'h0000_0001);
    wr(12'h03C, 32'h0000_0002);
    setPin(0, 1'b1, w); chk("R9 wake pin0", 32'(w), 1);
    rd(12'h048, d); chk("R5 rise sets", d, 32'h1);
    chk("R8 irq0", {29'b0, irqPin0, irqPin1, irqOther}, 32'b100);
    setPin(1, 1'b1, w);
    rd(12'h048, d); chk("R5 rise not enabled", d, 32'h1);
    setPin(1, 1'b0, w);
    rd(12'h048, d); chk("R5 fall sets", d, 32'h3);
    chk("R8 irq1", {29'b0, irqPin0, irqPin1, irqOther}, 32'b110);
    wr(12'h048, 32'h0000_0000);
    rd(12'h048, d); chk("R7 zero write keeps", d, 32'h3);
    wr(12'h048, 32'h0000_0001);
    rd(12'h048, d); chk("R7 w1c one bit", d, 32'h2);
    setPin(2, 1'b1, w); chk("R9 no wake pin2", 32'(w), 0);
    wr(12'h048, 32'h0000_0002);
    chk("R8 irqs clear", {29'b0, irqPin0, irqPin1, irqOther}, 0);
    wr(12'h034, 32'h0000_0100);
    setPin(40, 1'b1, w);
    rd(12'h04C, d); chk("R5 bank1 rise", d, 32'h100);
    chk("R8 irqOther", {29'b0, irqPin0, irqPin1, irqOther}, 32'b001);
    wr(12'h04C, 32'h0000_0100);
    chk("R8 irqOther clear", 32'(irqOther), 0);
  endtask

  task automatic testOutputNoEdge();
    logic [31:0] d;
    logic w;
    wr(12'h130, 32'h0000_0010);
    wr(12'h13C, 32'h0000_0010);
    setPin(100, 1'b1, w);
    setPin(100, 1'b0, w);
    rd(12'h148, d); chk("R6 output pin no status", d, 0);
    chk("R9 output pin no wake", 32'(w), 0);
  endtask

  task automatic testAddressing();
    logic [31:0] d;
    wr(12'h05C, 32'hA5A5_1234);
    wr(12'h070, 32'h0BAD_CAFE);
    rd(12'h05C, d); chk("R12 afLo1", d, 32'hA5A5_1234);
    rd(12'h070, d); chk("R12 afHi3", d, 32'h0BAD_CAFE);
    rd(12'h054, d); chk("R12 afLo0 untouched", d, 0);
    wr(12'h20C, 32'hFFFF_FFFF);
    chk("R10 no err", 32'(busErr), 0);
    rd(12'h20C, d); chk("R10 reads zero", d, 0);
    rd(12'h00C, d); chk("R10 dir0 unchanged", d, 0);
    wr(12'h074, 32'h1);
    chk("R11 err pulse", 32'(busErr), 1);
    @(negedge clk);
    chk("R11 err one cycle", 32'(busErr), 0);
    rd(12'h074, d); chk("R11 unmapped read", d, 0);
    wr(12'h00D, 32'hFFFF_FFFF);
    chk("R11 misaligned err", 32'(busErr), 1);
    rd(12'h00C, d); chk("R11 misaligned no write", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    testReset();
    testOutputs();
    testEdges();
    testOutputNoEdge();
    testAddressing();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule